// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-driven master for the two-wire PHY management bus. Software composes a complete management frame (start pattern, opcode, PHY address, register address, turnaround and data) as one 32-bit command word and writes it into the command register. The block then sends a run of 32 preamble ones followed by the 32 command bits, most significant bit first, on the management data line. It generates the management clock from the system clock with a divisor chosen by a small configuration field.

For a read, the block releases the data line from the turnaround onward. It samples the 16 data bits the PHY returns and writes them into the low half of the same command register, where software picks them up. A status bit shows when the engine is idle and ready for the next command. A control bit enables the port. With the bit clear, nothing is driven, and clearing it during a frame aborts that frame. Registers sit behind a simple word-addressed write/read port with a one-cycle registered read.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, mdc and mdio_oe are 0. Register 0 (control) reads 0. Register 1 (configuration) reads 0x0008_0000, which is divisor code 2 in bits 20:18. Register 2 (status) reads 0x4. Register 3 (command) reads 0.
- R2: A write to register 3 while idle and enabled starts a frame of 64 MDC periods. The first 32 bit periods carry a 1. Bit period 32+i carries command bit 31-i. The command layout is: bits 31:30 start, 29:28 opcode, 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data.
- R3: Configuration bits 20:18 select the MDC period in system clocks: code 0 gives 8 and any other code n gives 16·n, so code 2 gives 32 and code 3 gives 48. Each period is low for the first half and high for the second. The k-th rising MDC edge of a frame comes half + k·period cycles after the write edge, and MDC stays low while no frame runs.
- R4: The driven data line changes only in the cycle in which MDC falls. The input is captured on the clock edge that raises MDC.
- R5: For opcode 10 (read), mdio_oe is 0 for the last 18 bit periods (turnaround and data) and 1 before them. For every other opcode, mdio_oe is 1 for the whole frame.
- R6: When a read frame ends, the 16 sampled bits (first sampled = bit 15) replace command bits 15:0 and bits 31:16 keep their values. An absent PHY, whose line floats high, gives 0xFFFF. A non-read frame leaves the command register unchanged.
- R7: Status bit 2 is 0 from the edge that accepts a command until the edge that ends the frame (64 periods later), and 1 otherwise.
- R8: A write to register 3 while a frame is in progress is ignored: the command register and the frame in progress do not change.
- R9: Control bit 4 enables the port. While it is 0, a command write is stored but starts no frame, and mdc and mdio_oe stay 0. Clearing it during a frame aborts the frame: within three cycles mdc and mdio_oe are 0 and status bit 2 is 1.
- R10: The divisor is taken when a frame starts. A configuration write during a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 configuration, 2 status, 3 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the register selected in the previous cycle |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data to drive |
| mdio_oe | output | 1 | Output enable of the data line driver |

## Verification
The assertions check several rules on every cycle. The driver is off whenever no frame runs, and MDC stays low when idle. The driven bit moves only with a falling MDC. A frame begins only after an enabled command write. The upper command bits hold through a frame, and the output enable follows the read or write pattern, checked against a count of MDC falling edges. Other behaviour needs the bench's scenarios: the exact bit stream and its timing for each divisor code, the data returned from a responding or an absent PHY, the ignored busy write, the divisor change that only applies to the next frame, and the abort on disable.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CFG  = 2'd1,
    RA_STAT = 2'd2,
    RA_CMD  = 2'd3
  } mdio_reg_e;

  localparam int CMD_W     = 32;
  localparam int PRE_LEN   = 32;
  localparam int RD_DATA_W = 16;
  localparam int TA_W      = 2;
  localparam int OP_MSB    = 29;
  localparam int OP_LSB    = 28;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam int EN_BIT   = 4;
  localparam int IDLE_BIT = 2;
  localparam int DIV_LSB  = 18;

  function automatic logic is_read_op(input logic [CMD_W-1:0] w);
    return w[OP_MSB:OP_LSB] == OP_RD;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int CODE_W   = 3,
  parameter int DIV_UNIT = 16,
  parameter int DIV_ZERO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              mdc,
  output logic              bit_end,
  output logic              sample
);
  localparam int MAX_DIV = ((1 << CODE_W) - 1) * DIV_UNIT;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] half;

  function automatic logic [CNT_W-1:0] div_of(input logic [CODE_W-1:0] c);
    if (c == '0) return CNT_W'(DIV_ZERO);
    return CNT_W'(int'(c) * DIV_UNIT);
  endfunction

  assign half    = div_q >> 1;
  assign bit_end = run && (cnt == div_q - CNT_W'(1));
  assign sample  = run && (cnt == half - CNT_W'(1));
  assign cnt_nxt = bit_end ? '0 : cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= CNT_W'(DIV_ZERO);
      cnt   <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      div_q <= div_of(code);
      cnt   <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      mdc <= (cnt_nxt >= half);
    end
  end
endmodule

// File: rtl/mdio_shift_engine.sv
`timescale 1ns/1ps
module mdio_shift_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 port_en,
  input  logic [CMD_W-1:0]     cmd_word,
  input  logic                 bit_end,
  input  logic                 sample,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 wb_valid,
  output logic [RD_DATA_W-1:0] wb_data
);
  localparam int TOTAL      = PRE_LEN + CMD_W;
  localparam int BIT_W      = $clog2(TOTAL);
  localparam int POS_W      = $clog2(CMD_W);
  localparam int OE_OFF     = TOTAL - (RD_DATA_W + TA_W);
  localparam int DATA_START = TOTAL - RD_DATA_W;

  logic [BIT_W-1:0]     bitn;
  logic [BIT_W-1:0]     bitn_nxt;
  logic [CMD_W-1:0]     word;
  logic                 rd;
  logic [RD_DATA_W-1:0] cap;
  logic                 last_bit;

  function automatic logic frame_bit(input logic [BIT_W-1:0] idx,
                                     input logic [CMD_W-1:0] w);
    logic [POS_W-1:0] pos;
    if (int'(idx) < PRE_LEN) return 1'b1;
    pos = POS_W'(TOTAL - 1 - int'(idx));
    return w[pos];
  endfunction

  function automatic logic drive_on(input logic [BIT_W-1:0] idx, input logic r);
    return !(r && (int'(idx) >= OE_OFF));
  endfunction

  assign bitn_nxt = bitn + BIT_W'(1);
  assign last_bit = (bitn == BIT_W'(TOTAL - 1));
  assign wb_valid = busy && port_en && bit_end && last_bit && rd;
  assign wb_data  = cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bitn    <= '0;
      word    <= '0;
      rd      <= 1'b0;
      cap     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (start && port_en) begin
        busy    <= 1'b1;
        bitn    <= '0;
        word    <= cmd_word;
        rd      <= is_read_op(cmd_word);
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else if (!port_en) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      if (sample && rd && (int'(bitn) >= DATA_START))
        cap <= {cap[RD_DATA_W-2:0], mdio_i};
      if (bit_end) begin
        if (last_bit) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bitn    <= bitn_nxt;
          mdio_o  <= frame_bit(bitn_nxt, word);
          mdio_oe <= drive_on(bitn_nxt, rd);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_CODE_W = 3,
  parameter int DIV_RST    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [CMD_W-1:0]      reg_wdata,
  output logic [CMD_W-1:0]      reg_rdata,
  input  logic                  busy,
  input  logic                  wb_valid,
  input  logic [RD_DATA_W-1:0]  wb_data,
  output logic                  port_en,
  output logic [DIV_CODE_W-1:0] div_code,
  output logic [CMD_W-1:0]      cmd_q,
  output logic                  start
);
  mdio_reg_e        sel;
  logic [CMD_W-1:0] rd_mux;

  assign sel   = mdio_reg_e'(reg_addr);
  assign start = reg_wr && (sel == RA_CMD) && !busy;

  always_comb begin
    rd_mux = '0;
    case (sel)
      RA_CTRL: rd_mux[EN_BIT] = port_en;
      RA_CFG:  rd_mux[DIV_LSB +: DIV_CODE_W] = div_code;
      RA_STAT: rd_mux[IDLE_BIT] = !busy;
      RA_CMD:  rd_mux = cmd_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_en   <= 1'b0;
      div_code  <= DIV_CODE_W'(DIV_RST);
      cmd_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && sel == RA_CTRL) port_en <= reg_wdata[EN_BIT];
      if (reg_wr && sel == RA_CFG) div_code <= reg_wdata[DIV_LSB +: DIV_CODE_W];
      if (start) cmd_q <= reg_wdata;
      else if (wb_valid) cmd_q[RD_DATA_W-1:0] <= wb_data;
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mdio_frame_master.sv
`timescale 1ns/1ps
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int DIV_CODE_W = 3,
  parameter int DIV_UNIT   = 16,
  parameter int DIV_ZERO   = 8,
  parameter int DIV_RST    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                  busy;
  logic                  port_en;
  logic [DIV_CODE_W-1:0] div_code;
  logic [CMD_W-1:0]      cmd_q;
  logic                  start;
  logic                  wb_valid;
  logic [RD_DATA_W-1:0]  wb_data;
  logic                  bit_end;
  logic                  sample;

  mdio_regs #(.DIV_CODE_W(DIV_CODE_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .wb_valid(wb_valid), .wb_data(wb_data), .port_en(port_en),
    .div_code(div_code), .cmd_q(cmd_q), .start(start)
  );

  mdio_clk_div #(.CODE_W(DIV_CODE_W), .DIV_UNIT(DIV_UNIT), .DIV_ZERO(DIV_ZERO)) u_div (
    .clk(clk), .rst(rst), .run(busy), .code(div_code),
    .mdc(mdc), .bit_end(bit_end), .sample(sample)
  );

  mdio_shift_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .port_en(port_en), .cmd_word(reg_wdata),
    .bit_end(bit_end), .sample(sample), .mdio_i(mdio_i), .busy(busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .wb_valid(wb_valid), .wb_data(wb_data)
  );
endmodule

// File: rtl/mdio_frame_checker.sv
`timescale 1ns/1ps
module mdio_frame_checker
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             busy,
  input logic             port_en,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [CMD_W-1:0] cmd_q
);
  localparam int OE_OFF = PRE_LEN + CMD_W - (RD_DATA_W + TA_W);

  logic       mdc_d;
  logic [6:0] fall_cnt;
  logic       rd;

  assign rd = is_read_op(cmd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_d    <= 1'b0;
      fall_cnt <= '0;
    end else begin
      mdc_d <= mdc;
      if (!busy) fall_cnt <= '0;
      else if (mdc_d && !mdc) fall_cnt <= fall_cnt + 7'd1;
    end
  end

  AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R9
  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !mdc); // R3
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R4
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_q[CMD_W-1:RD_DATA_W])); // R8
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_addr == 2'd3 && port_en)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd && int'(fall_cnt) >= OE_OFF) |-> !mdio_oe); // R5
  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd && int'(fall_cnt) < OE_OFF - 1) |-> mdio_oe); // R5
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd) |-> mdio_oe); // R5
endmodule

bind mdio_frame_master mdio_frame_checker u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .busy(busy),
  .port_en(port_en), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_q(cmd_q)
);

// File: tb/sim_mdio_frame_master.sv
`timescale 1ns/1ps
module sim_mdio_frame_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, line;
  logic        phy_bit = 1'b1;
  logic        phy_on = 1'b0;
  logic [15:0] phy_val = '0;

  always #2.5 clk = ~clk;

  assign line = mdio_oe ? mdio_o : phy_bit;

  mdio_frame_master u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(line),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // fields: code[47:45] op[44:43] phy[42:38] reg[37:33] data[32:17] present[16] val[15:0]
  localparam logic [47:0] VEC [4] = '{
    {3'd2, 2'b10, 5'd5,  5'd1,  16'h0000, 1'b1, 16'h7849},
    {3'd3, 2'b01, 5'd31, 5'd0,  16'hA55A, 1'b0, 16'h0000},
    {3'd0, 2'b10, 5'd0,  5'd2,  16'h1234, 1'b0, 16'h0000},
    {3'd5, 2'b11, 5'd10, 5'd31, 16'h0F0F, 1'b1, 16'h0000}
  };

  // monitor state
  logic        prev_mdc = 1'b0, prev_oe = 1'b0, prev_o = 1'b1;
  int          rises = 0, first_rise = 0, last_rise = 0, viol = 0;
  logic [63:0] obs_line = '0, obs_oe = '0;
  logic        oe_seen = 1'b0;

  function automatic logic resp(input int b);
    if (!phy_on) return 1'b1;
    if (b == 47) return 1'b0;
    if (b >= 48 && b <= 63) return phy_val[63-b];
    return 1'b1;
  endfunction

  initial forever begin
    @(posedge clk);
    cyc = cyc + 1;
  end

  initial forever begin
    @(negedge clk);
    if (mdio_oe) oe_seen = 1'b1;
    if (mdc && !prev_mdc) begin
      if (rises < 64) begin
        obs_line[rises] = line;
        obs_oe[rises]   = mdio_oe;
      end
      if (rises == 0) first_rise = cyc;
      last_rise = cyc;
      rises = rises + 1;
    end
    if (!mdc && prev_mdc) phy_bit = resp(rises);
    if (mdio_oe && prev_oe && (mdio_o != prev_o) && !(prev_mdc && !mdc)) viol = viol + 1;
    prev_mdc = mdc;
    prev_oe  = mdio_oe;
    prev_o   = mdio_o;
  end

  task automatic clear_mon();
    rises = 0; first_rise = 0; last_rise = 0; oe_seen = 1'b0;
    obs_line = '0; obs_oe = '0;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int div_of(input logic [2:0] c);
    return (c == 3'd0) ? 8 : int'(c) * 16;
  endfunction

  task automatic run_frame(input logic [2:0] code, input logic [1:0] op,
                           input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] dat, input logic pres,
                           input logic [15:0] val);
    logic [31:0] cmd, rb, st;
    logic [63:0] exp_line, mask, exp_oe;
    logic [15:0] rdv;
    bit          is_rd;
    int          w, dv, hf;
    cmd   = {2'b01, op, pa, ra, 2'b10, dat};
    is_rd = (op == 2'b10);
    rdv   = pres ? val : 16'hFFFF;
    dv    = div_of(code);
    hf    = dv / 2;
    for (int b = 0; b < 64; b++) begin
      exp_line[b] = (b < 32) ? 1'b1 : cmd[63-b];
      mask[b]     = 1'b1;
      exp_oe[b]   = 1'b1;
      if (is_rd && b >= 46) exp_oe[b] = 1'b0;
      if (is_rd && (b == 46 || b == 47)) mask[b] = 1'b0;
      if (is_rd && b >= 48) exp_line[b] = rdv[63-b];
    end
    reg_write(2'd1, {11'd0, code, 18'd0});
    phy_on = pres; phy_val = val;
    clear_mon();
    reg_write(2'd3, cmd);
    w = cyc;
    wait_until(w + 64 * dv + 2);
    check(first_rise == w + hf, "R3 first MDC rise", 64'(first_rise - w), 64'(hf));
    check(last_rise == w + 63 * dv + hf, "R3 last MDC rise", 64'(last_rise - w),
          64'(63 * dv + hf));
    check(((obs_line ^ exp_line) & mask) == '0, "R2 bit stream", obs_line & mask,
          exp_line & mask);
    check(obs_oe == exp_oe, "R5 output enable pattern", obs_oe, exp_oe);
    reg_read(2'd3, rb);
    check(rb == (is_rd ? {cmd[31:16], rdv} : cmd), "R6 command readback", 64'(rb),
          64'(is_rd ? {cmd[31:16], rdv} : cmd));
    reg_read(2'd2, st);
    check(st == 32'h4, "R7 idle after frame", 64'(st), 64'h4);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] c1, c2;
    int          w, r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(mdc == 1'b0, "R1 mdc after reset", 64'(mdc), 64'h0);
    check(mdio_oe == 1'b0, "R1 oe after reset", 64'(mdio_oe), 64'h0);
    reg_read(2'd0, d); check(d == 32'h0, "R1 control reset", 64'(d), 64'h0);
    reg_read(2'd1, d); check(d == 32'h0008_0000, "R1 config reset", 64'(d), 64'h0008_0000);
    reg_read(2'd2, d); check(d == 32'h4, "R1 status reset", 64'(d), 64'h4);
    reg_read(2'd3, d); check(d == 32'h0, "R1 command reset", 64'(d), 64'h0);

    // R9 disabled port: write stored, no frame
    clear_mon();
    reg_write(2'd3, 32'h6001_0000 | 32'h0082_0000);
    repeat (200) @(negedge clk);
    check(rises == 0 && !oe_seen, "R9 no frame while disabled", 64'(rises), 64'h0);
    reg_read(2'd3, d);
    check(d == 32'h6083_0000, "R9 command stored while disabled", 64'(d), 64'h6083_0000);

    reg_write(2'd0, 32'h10);

    // main vector table: R2 R3 R5 R6 R7
    for (int i = 0; i < 4; i++)
      run_frame(VEC[i][47:45], VEC[i][44:43], VEC[i][42:38], VEC[i][37:33],
                VEC[i][32:17], VEC[i][16], VEC[i][15:0]);
    check(viol == 0, "R4 data changes only on MDC fall", 64'(viol), 64'h0);

    // R7 R8: busy status and ignored write during a frame
    reg_write(2'd1, 32'h0);
    c1 = 32'h5A5A_C3C3;
    c2 = 32'h6F00_0000;
    phy_on = 1'b0;
    clear_mon();
    reg_write(2'd3, c1);
    w = cyc;
    repeat (40) @(negedge clk);
    reg_read(2'd2, d);
    check(d == 32'h0, "R7 status busy mid-frame", 64'(d), 64'h0);
    reg_write(2'd3, c2);
    reg_read(2'd3, d);
    check(d == c1, "R8 busy write ignored", 64'(d), 64'(c1));
    // R10: config change mid-frame does not alter this frame
    reg_write(2'd1, {11'd0, 3'd3, 18'd0});
    wait_until(w + 64 * 8 + 2);
    check(last_rise == w + 63 * 8 + 4, "R8 R10 frame timing unchanged", 64'(last_rise - w),
          64'(63 * 8 + 4));
    reg_read(2'd3, d);
    check(d == c1, "R8 command after frame", 64'(d), 64'(c1));
    clear_mon();
    reg_write(2'd3, c2);
    w = cyc;
    wait_until(w + 30);
    check(first_rise == w + 24, "R10 new divisor on next frame", 64'(first_rise - w), 64'd24);
    wait_until(w + 64 * 48 + 2);

    // R9 abort on disable
    reg_write(2'd1, 32'h0);
    clear_mon();
    reg_write(2'd3, c1);
    repeat (100) @(negedge clk);
    reg_write(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 abort drops mdc and oe",
          64'({mdc, mdio_oe}), 64'h0);
    reg_read(2'd2, d);
    check(d == 32'h4, "R9 idle after abort", 64'(d), 64'h4);
    r0 = rises;
    repeat (100) @(negedge clk);
    check(rises == r0, "R9 no clocks after abort", 64'(rises), 64'(r0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule